// File: doc/BRIEF.md
# Multichannel TDM Playback Receiver

This block turns up to three time-division-multiplexed serial playback streams into twelve parallel 24-bit channel words. The bit clock comes from outside and clocks the whole block. A frame clock marks where each frame starts. Every frame is cut into 32-bit slots. Each slot carries one channel word, sent MSB first in two's complement.

A mode input sets the frame length: 512, 256 or 128 bit clocks. The mode also sets how the twelve channels are spread over the input pins. Long frames carry all channels on one pin. Short frames spread them over two or three pins. A format input sets where the word sits inside its slot and how long it is. Short right-justified words are widened to 24 bits with the sign and full-scale level kept.

Decoded words are collected while a frame arrives. All twelve are released together when the next frame begins, with a single-cycle valid strobe. A frame whose length does not match the mode is thrown away.

Top module: `tdm_playback_rx`

## Requirements
- R1: While reset is asserted and after it is released, every channel word reads zero and `frameValid` is low until the first completed frame is released.
- R2: Data pins are sampled on the rising edge of `bitClk`. A frame starts on the edge where `frameSync` is sampled high after being sampled low, and the bit sampled on that edge is bit 0 of slot 0. Slot s covers frame bits 32*s to 32*s+31, and words arrive MSB first.
- R3: With `modeSel`=00 (512-clock frame), slots 0..11 of `sdIn[0]` give channels 0..11. Channel k sits at `chWords[24*k+23:24*k]`. Slots 12..15 and pins `sdIn[2:1]` have no effect.
- R4: With `modeSel`=01 (256-clock frame), slots 0..7 of `sdIn[0]` give channels 0..7 and slots 0..3 of `sdIn[1]` give channels 8..11. All other slots and `sdIn[2]` have no effect.
- R5: With `modeSel`=10 or 11 (128-clock frame), slots 0..3 of `sdIn[0]`, `sdIn[1]` and `sdIn[2]` give channels 0..3, 4..7 and 8..11 respectively.
- R6: `fmtSel`=000, 001 and 010 select 16-, 20- and 24-bit right-justified words, which occupy the last 16, 20 or 24 bits of their slot. The word lands in the top bits of the 24-bit output and the unused low bits are zero.
- R7: `fmtSel`=011, and the unused codes 101..111, select a 24-bit left-justified word in slot bits 0..23.
- R8: `fmtSel`=100 selects a 24-bit word in slot bits 1..24, one bit clock after the slot begins.
- R9: A completed frame is released on the edge where the next frame start is sampled. All twelve words change together on that edge, and `frameValid` is high for exactly the following cycle. Outputs hold at all other times.
- R10: A frame with fewer or more bit clocks than the mode's frame length, counted between starts, raises no strobe and leaves the outputs unchanged. The next correctly sized frame is released normally.
- R11: The first frame start after reset releases nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame clock; a rising level marks frame bit 0 |
| modeSel | input | 2 | Frame length and pin mapping: 00=512, 01=256, 10/11=128 clocks |
| fmtSel | input | 3 | Word format inside the slot (see R6-R8) |
| sdIn | input | 3 | Serial data pins, index 0 is the first pin |
| chWords | output | 288 | Twelve 24-bit channel words, channel k at bits 24k+23..24k |
| frameValid | output | 1 | One-cycle strobe marking freshly released words |

## Verification
A corrupted bit counter or frame-start detector shows up one frame later, at the next release. Every channel then comes out shifted, or the strobe is missing or extra. A wrong slot or pin index shows up at that same release as a word in the wrong channel, or as a channel left stale. A bad alignment shift shows up as wrong low bits in the short right-justified formats, and the tests send values with the sign bit set so this is visible. Because of this one-frame delay, every test ends by forcing a new frame start and then checks both the strobe cycle and the cycle after it.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  localparam int SLOT_IDX_W = 5;
  localparam int PAD_W      = 5;
  localparam int SPP_LOG_W  = 3;
  localparam int SHORT_LEN_A = 16;
  localparam int SHORT_LEN_B = 20;

  typedef enum logic [2:0] {
    FMT_RJ16 = 3'd0,
    FMT_RJ20 = 3'd1,
    FMT_RJ24 = 3'd2,
    FMT_LJ24 = 3'd3,
    FMT_I2S  = 3'd4
  } fmt_e;

  typedef struct packed {
    logic                  shiftEn;
    logic                  wordEnd;
    logic                  commit;
    logic [SLOT_IDX_W-1:0] slot;
    logic [PAD_W-1:0]      padBits;
    logic [SPP_LOG_W-1:0]  sppLog;
  } rx_strobe_t;

endpackage

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int WORD_BITS = 24,
  parameter int MAX_SLOTS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic [1:0] modeSel,
  input  logic [2:0] fmtSel,
  output rx_strobe_t strb
);

  localparam int SB_W      = $clog2(SLOT_BITS);
  localparam int MAX_FRAME = MAX_SLOTS * SLOT_BITS;
  localparam int CW        = $clog2(MAX_FRAME) + 1;
  localparam int MAX_LOG   = $clog2(MAX_SLOTS);

  typedef logic [CW-1:0] cnt_t;
  typedef logic [SB_W:0] bit_t;

  logic       fsPrev;
  logic       startNow;
  logic       inFrame;
  logic [1:0] modeIdx;
  cnt_t       bitCnt;
  cnt_t       pos;
  cnt_t       frameLen;
  bit_t       bitIdx;
  bit_t       wStart;
  bit_t       wLen;
  bit_t       wStop;

  assign startNow = frameSync & ~fsPrev;
  assign modeIdx  = (modeSel == 2'b11) ? 2'b10 : modeSel;
  assign frameLen = cnt_t'(MAX_FRAME) >> modeIdx;
  assign pos      = startNow ? '0 : bitCnt;
  assign inFrame  = pos < frameLen;
  assign bitIdx   = bit_t'(pos[SB_W-1:0]);

  // Word placement inside a slot for each format
  always_comb begin
    wStart = '0;
    wLen   = bit_t'(WORD_BITS);
    case (fmt_e'(fmtSel))
      FMT_RJ16: begin
        wLen   = bit_t'(SHORT_LEN_A);
        wStart = bit_t'(SLOT_BITS - SHORT_LEN_A);
      end
      FMT_RJ20: begin
        wLen   = bit_t'(SHORT_LEN_B);
        wStart = bit_t'(SLOT_BITS - SHORT_LEN_B);
      end
      FMT_RJ24: wStart = bit_t'(SLOT_BITS - WORD_BITS);
      FMT_I2S:  wStart = bit_t'(1);
      default:  wStart = '0;
    endcase
  end

  assign wStop = wStart + wLen;

  always_comb begin
    strb.shiftEn = inFrame && (bitIdx >= wStart) && (bitIdx < wStop);
    strb.wordEnd = inFrame && ((bitIdx + bit_t'(1)) == wStop);
    strb.commit  = startNow && (bitCnt == frameLen);
    strb.slot    = SLOT_IDX_W'(pos >> SB_W);
    strb.padBits = PAD_W'(bit_t'(WORD_BITS) - wLen);
    strb.sppLog  = SPP_LOG_W'(MAX_LOG) - SPP_LOG_W'(modeIdx);
  end

  // Bit counter: reset value lies beyond every frame length, so nothing
  // counts as complete until a start has been seen.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev <= 1'b0;
      bitCnt <= '1;
    end else begin
      fsPrev <= frameSync;
      if (startNow)
        bitCnt <= cnt_t'(1);
      else if (bitCnt <= frameLen)
        bitCnt <= bitCnt + cnt_t'(1);
    end
  end

  // Checker state: spacing between releases and shifts per word
  cnt_t gapCnt;
  bit_t shiftSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '1;
    end else if (strb.commit) begin
      gapCnt <= cnt_t'(1);
    end else if (gapCnt != '1) begin
      gapCnt <= gapCnt + cnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftSeen <= '0;
    end else if (startNow) begin
      shiftSeen <= strb.shiftEn ? bit_t'(1) : '0;
    end else if (strb.wordEnd) begin
      shiftSeen <= '0;
    end else if (strb.shiftEn) begin
      shiftSeen <= shiftSeen + bit_t'(1);
    end
  end

  // R10
  release_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (gapCnt >= (cnt_t'(MAX_FRAME) >> 2)));

  // R6
  word_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordEnd && !startNow) |-> ((shiftSeen + bit_t'(1)) == wLen));

endmodule

// File: rtl/tdm_rx_datapath.sv
module tdm_rx_datapath
  import tdm_rx_pkg::*;
#(
  parameter int NUM_CH    = 12,
  parameter int NUM_PINS  = 3,
  parameter int WORD_BITS = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rx_strobe_t                  strb,
  input  logic [NUM_PINS-1:0]         sdIn,
  output logic [NUM_CH*WORD_BITS-1:0] chWords,
  output logic                        frameValid
);

  localparam int IDX_W = $clog2(NUM_PINS) + SLOT_IDX_W + 1;

  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [IDX_W-1:0]     idx_t;

  logic [NUM_PINS-1:0][WORD_BITS-1:0] alignedWord;
  logic [NUM_PINS-1:0][IDX_W-1:0]     pinChIdx;

  // One shift accumulator per serial pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    word_t acc;
    word_t nextAcc;

    assign nextAcc = {acc[WORD_BITS-2:0], sdIn[p]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        acc <= '0;
      else if (strb.shiftEn)
        acc <= nextAcc;
    end

    assign alignedWord[p] = nextAcc << strb.padBits;
    assign pinChIdx[p]    = (idx_t'(p) << strb.sppLog) + idx_t'(strb.slot);
  end

  // Per-channel shadow word and released output word
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    word_t shadowWord;
    word_t outWord;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowWord <= '0;
      end else if (strb.wordEnd) begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (pinChIdx[p] == idx_t'(c))
            shadowWord <= alignedWord[p];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        outWord <= '0;
      else if (strb.commit)
        outWord <= shadowWord;
    end

    assign chWords[c*WORD_BITS +: WORD_BITS] = outWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      frameValid <= 1'b0;
    else
      frameValid <= strb.commit;
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // R9
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> $stable(chWords));

endmodule

// File: rtl/tdm_playback_rx.sv
module tdm_playback_rx
  import tdm_rx_pkg::*;
#(
  parameter int NUM_CH    = 12,
  parameter int NUM_PINS  = 3,
  parameter int SLOT_BITS = 32,
  parameter int WORD_BITS = 24,
  parameter int MAX_SLOTS = 16
) (
  input  logic                        bitClk,
  input  logic                        rstN,
  input  logic                        frameSync,
  input  logic [1:0]                  modeSel,
  input  logic [2:0]                  fmtSel,
  input  logic [NUM_PINS-1:0]         sdIn,
  output logic [NUM_CH*WORD_BITS-1:0] chWords,
  output logic                        frameValid
);

  rx_strobe_t strb;

  tdm_rx_ctrl #(
    .SLOT_BITS (SLOT_BITS),
    .WORD_BITS (WORD_BITS),
    .MAX_SLOTS (MAX_SLOTS)
  ) i_ctrl (
    .clk       (bitClk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .modeSel   (modeSel),
    .fmtSel    (fmtSel),
    .strb      (strb)
  );

  tdm_rx_datapath #(
    .NUM_CH    (NUM_CH),
    .NUM_PINS  (NUM_PINS),
    .WORD_BITS (WORD_BITS)
  ) i_datapath (
    .clk        (bitClk),
    .rstN       (rstN),
    .strb       (strb),
    .sdIn       (sdIn),
    .chWords    (chWords),
    .frameValid (frameValid)
  );

endmodule

// File: tb/test_tdm_playback_rx.sv
module test_tdm_playback_rx;

  localparam int NCH = 12;
  localparam int WB  = 24;
  localparam int NP  = 3;

  logic            bitClk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameSync = 1'b0;
  logic [1:0]      modeSel = 2'b00;
  logic [2:0]      fmtSel = 3'b000;
  logic [NP-1:0]   sdIn = '0;
  logic [NCH*WB-1:0] chWords;
  logic            frameValid;

  int checkCnt = 0;
  int failCnt  = 0;

  logic [WB-1:0] txData  [NCH];
  logic [WB-1:0] expData [NCH];

  always #4 bitClk = ~bitClk;

  tdm_playback_rx i_tdm_playback_rx (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .modeSel    (modeSel),
    .fmtSel     (fmtSel),
    .sdIn       (sdIn),
    .chWords    (chWords),
    .frameValid (frameValid)
  );

  task automatic checkBit(string req, string what, logic act, logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkWords(string req);
    for (int k = 0; k < NCH; k++) begin
      checkCnt++;
      if (chWords[k*WB +: WB] !== expData[k]) begin
        failCnt++;
        $display("FAIL %s channel %0d: actual %h expected %h",
                 req, k, chWords[k*WB +: WB], expData[k]);
      end
    end
  endtask

  function automatic void fmtPlace(input int fmt, output int st, output int ln);
    case (fmt)
      0:       begin ln = 16; st = 16; end
      1:       begin ln = 20; st = 12; end
      2:       begin ln = 24; st = 8;  end
      4:       begin ln = 24; st = 1;  end
      default: begin ln = 24; st = 0;  end
    endcase
  endfunction

  task automatic fillData(int seed);
    for (int k = 0; k < NCH; k++)
      txData[k] = WB'((32'h9E3779B9 * (k + 1 + seed * 13)) >> 5);
  endtask

  task automatic setExpected(int fmt);
    int st;
    int ln;
    fmtPlace(fmt, st, ln);
    for (int k = 0; k < NCH; k++)
      expData[k] = txData[k] & (24'hFFFFFF << (WB - ln));
  endtask

  // Drives one frame of len bit clocks; unused bits carry a junk pattern
  task automatic sendFrame(int mode, int fmt, int len);
    int spp;
    int st;
    int ln;
    spp = 16 >> ((mode == 3) ? 2 : mode);
    fmtPlace(fmt, st, ln);
    for (int pos = 0; pos < len; pos++) begin
      @(negedge bitClk);
      frameSync = (pos == 0);
      modeSel   = 2'(mode);
      fmtSel    = 3'(fmt);
      for (int p = 0; p < NP; p++) begin
        int slot;
        int b;
        int ch;
        logic bitv;
        slot = pos / 32;
        b    = pos % 32;
        ch   = p * spp + slot;
        bitv = (((pos * 5) + p) % 3) != 0;
        if (slot < spp && ch < NCH && b >= st && b < st + ln)
          bitv = txData[ch][WB-1-(b-st)];
        sdIn[p] = bitv;
      end
    end
  endtask

  // Starts a new frame, then checks the release strobe and hold behaviour
  task automatic closeFrame(string req, logic expValid);
    @(negedge bitClk);
    frameSync = 1'b1;
    sdIn = '0;
    @(negedge bitClk);
    frameSync = 1'b0;
    checkBit(req, "strobe at release", frameValid, expValid);
    checkWords(req);
    @(negedge bitClk);
    checkBit("R9", "strobe one cycle later", frameValid, 1'b0);
    checkWords("R9 hold");
  endtask

  task automatic testReset;
    for (int k = 0; k < NCH; k++) expData[k] = '0;
    checkBit("R1", "strobe after reset", frameValid, 1'b0);
    checkWords("R1");
  endtask

  task automatic testFirstStart;
    closeFrame("R11", 1'b0);
  endtask

  task automatic test512Lj;
    fillData(1);
    sendFrame(0, 3, 512);
    setExpected(3);
    closeFrame("R2 R3 R7", 1'b1);
  endtask

  task automatic test512Rj16;
    fillData(2);
    sendFrame(0, 0, 512);
    setExpected(0);
    closeFrame("R3 R6", 1'b1);
  endtask

  task automatic test256Rj20;
    fillData(3);
    sendFrame(1, 1, 256);
    setExpected(1);
    closeFrame("R4 R6", 1'b1);
  endtask

  task automatic test128Rj24;
    fillData(4);
    sendFrame(2, 2, 128);
    setExpected(2);
    closeFrame("R5 R6", 1'b1);
  endtask

  task automatic test128I2s;
    fillData(5);
    sendFrame(2, 4, 128);
    setExpected(4);
    closeFrame("R8", 1'b1);
  endtask

  task automatic testAltCodes;
    fillData(6);
    sendFrame(3, 7, 128);
    setExpected(7);
    closeFrame("R5 R7", 1'b1);
  endtask

  task automatic testBadLength;
    fillData(7);
    sendFrame(1, 2, 256 - 5);
    closeFrame("R10 short", 1'b0);
    sendFrame(1, 2, 256 + 3);
    closeFrame("R10 long", 1'b0);
    sendFrame(1, 2, 256);
    setExpected(2);
    closeFrame("R10 recover", 1'b1);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge bitClk);
    rstN = 1'b1;
    @(negedge bitClk);
    testReset();
    testFirstStart();
    test512Lj();
    test512Rj16();
    test256Rj20();
    test128Rj24();
    test128I2s();
    testAltCodes();
    testBadLength();
    finishRun();
  end

endmodule